// File: doc/BRIEF.md
# SIMD lane comparison unit

This block compares two 128-bit vector operands lane by lane. For every lane it writes a mask: all ones when the chosen relation holds for operand A against operand B, and all zeros when it does not. A 32-bit instruction word selects the operation. Three relations are available: equal, greater-or-equal and greater-than. Operands can be read as signed integers, unsigned integers or IEEE single-precision floats. Integer lanes can be 8, 16 or 32 bits wide.

A caller presents both operands and the instruction with a one-cycle request strobe. One clock later the unit returns a registered mask together with a valid strobe. If the instruction word is an encoding the unit does not handle, it raises an illegal flag in that cycle instead, and it keeps the previous mask.

Top module: `simd_cmp_unit`

## Requirements
- R1: After reset, `resValid` and `illegal` are 0 and `resMask` is all zeros.
- R2: A request is answered exactly one clock later. Either `resValid` or `illegal` is 1 in that cycle, never both. In any cycle that does not follow a request, both are 0.
- R3: Integer equality is selected when instr[11:8]=8, instr[4]=1 and instr[24:23]=2. The size field instr[21:20] gives the lane width: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits.
- R4: Signed greater-or-equal is selected when instr[11:8]=3, instr[4]=1 and instr[24:23]=0. The lanes are read as two's complement, and the lane width comes from instr[21:20] as in R3.
- R5: Unsigned greater-or-equal uses the same encoding as R4 except that instr[24:23]=2.
- R6: Greater-than uses instr[11:8]=3 and instr[4]=0. It is signed when instr[24:23]=0 and unsigned when instr[24:23]=2, and the lane width comes from instr[21:20].
- R7: Any integer compare with instr[21:20]=3 raises `illegal` and gives no valid result.
- R8: Float equality is selected when instr[11:8]=14, instr[4]=0, instr[21:20]=0 and instr[24:23]=0. It compares four 32-bit lanes, and +0 equals -0.
- R9: Float greater-or-equal uses instr[11:8]=14, instr[4]=0, instr[21:20]=0 and instr[24:23]=2. Float greater-than uses the same fields except instr[21:20]=2. Both follow numeric order, including negative values and infinities.
- R10: In a float compare, a lane where either operand is NaN gives a false result for every relation.
- R11: Any other encoding raises `illegal` and leaves `resMask` unchanged.
- R12: Every destination lane of the selected width is uniformly all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, one cycle per operation |
| instr | input | 32 | Instruction word that selects the compare |
| opA | input | 128 | First operand |
| opB | input | 128 | Second operand |
| resMask | output | 128 | Registered lane mask |
| resValid | output | 1 | Result valid, one cycle after an accepted request |
| illegal | output | 1 | Request carried an encoding the unit does not handle |

## Verification
The integer compares are driven with boundary bytes and halfwords: 0x80 against 0x7F, and all-ones against zero. These values give opposite answers under signed and unsigned reading, so they show which interpretation the unit applied. Patterns whose lanes differ in only one narrow sub-lane show whether the lane width is decoded correctly: the same operands must give different masks at 8, 16 and 32 bits.

The float cases mix signed zeros, negative values, infinities and NaN across the four lanes. They separate numeric ordering from raw bit ordering and check that NaN makes every relation false. Illegal encodings are sent right after a known result so that an unchanged mask can be seen at the outputs.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_GE = 2'd1,
    REL_GT = 2'd2
  } relKind_e;

  typedef enum logic [1:0] {
    FMT_SINT = 2'd0,
    FMT_UINT = 2'd1,
    FMT_FP   = 2'd2
  } numFmt_e;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2
  } laneW_e;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic     load;
    relKind_e rel;
    numFmt_e  fmt;
    laneW_e   lw;
  } cmpCtrl_t;

endpackage

// File: rtl/simd_int_lane.sv
module simd_int_lane
  import simd_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         isSigned,
  input  relKind_e     rel,
  output logic         hit
);
  logic eq, aGt;

  always_comb begin
    eq  = (a == b);
    aGt = isSigned ? ($signed(a) > $signed(b)) : (a > b);
    case (rel)
      REL_EQ:  hit = eq;
      REL_GE:  hit = eq | aGt;
      default: hit = aGt;
    endcase
  end
endmodule

// File: rtl/simd_fp_lane.sv
module simd_fp_lane
  import simd_cmp_pkg::*;
(
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  relKind_e    rel,
  output logic        hit
);
  logic aNan, bNan, bothZero, eq, aGt, anyNan;

  always_comb begin
    aNan     = (a[30:23] == 8'hFF) && (a[22:0] != '0);
    bNan     = (b[30:23] == 8'hFF) && (b[22:0] != '0);
    anyNan   = aNan | bNan;
    bothZero = (a[30:0] == '0) && (b[30:0] == '0);
    eq       = !anyNan && (bothZero || (a == b));
    // Magnitude order flips when both values are negative
    aGt      = !anyNan && !bothZero &&
               ((!a[31] && b[31]) ||
                (!a[31] && !b[31] && (a[30:0] > b[30:0])) ||
                ( a[31] &&  b[31] && (a[30:0] < b[30:0])));
    case (rel)
      REL_EQ:  hit = eq;
      REL_GE:  hit = eq | aGt;
      default: hit = aGt;
    endcase
  end
endmodule

// File: rtl/simd_cmp_ctrl.sv
module simd_cmp_ctrl
  import simd_cmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] instr,
  output cmpCtrl_t    ctrl,
  output logic        resValid,
  output logic        illegal
);
  logic [3:0] opField;
  logic [1:0] szField, uField;
  logic       bit4, legal, intSizeOk;
  relKind_e   rel;
  numFmt_e    fmt;
  laneW_e     lw;

  always_comb begin
    opField   = instr[11:8];
    szField   = instr[21:20];
    uField    = instr[24:23];
    bit4      = instr[4];
    intSizeOk = (szField != 2'd3);
    legal     = 1'b0;
    rel       = REL_EQ;
    fmt       = FMT_SINT;
    case (szField)
      2'd0:    lw = LW_8;
      2'd1:    lw = LW_16;
      default: lw = LW_32;
    endcase
    if (opField == 4'd8 && bit4 && uField == 2'd2) begin
      rel   = REL_EQ;
      fmt   = FMT_UINT;
      legal = intSizeOk;
    end else if (opField == 4'd3 && (uField == 2'd0 || uField == 2'd2)) begin
      rel   = bit4 ? REL_GE : REL_GT;
      fmt   = (uField == 2'd2) ? FMT_UINT : FMT_SINT;
      legal = intSizeOk;
    end else if (opField == 4'd14 && !bit4) begin
      fmt = FMT_FP;
      lw  = LW_32;
      if (szField == 2'd0 && uField == 2'd0) begin
        rel = REL_EQ; legal = 1'b1;
      end else if (szField == 2'd0 && uField == 2'd2) begin
        rel = REL_GE; legal = 1'b1;
      end else if (szField == 2'd2 && uField == 2'd2) begin
        rel = REL_GT; legal = 1'b1;
      end
    end
    ctrl.load = reqValid & legal;
    ctrl.rel  = rel;
    ctrl.fmt  = fmt;
    ctrl.lw   = lw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      resValid <= reqValid & legal;
      illegal  <= reqValid & ~legal;
    end
  end

  // R2: no answer without a request in the previous cycle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!resValid && !illegal));
  // R2: every request is answered one cycle later
  a_r2_answered: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (resValid || illegal));
  // R2: valid and illegal are exclusive
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resValid, illegal}));
  // R7: 64-bit integer lanes are rejected
  a_r7_size3_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && instr[11:8] == 4'd3 && instr[21:20] == 2'd3) |=> illegal);
endmodule

// File: rtl/simd_cmp_dp.sv
module simd_cmp_dp
  import simd_cmp_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmpCtrl_t         ctrl,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] resMask
);
  localparam int N8  = VEC_W / 8;
  localparam int N16 = VEC_W / 16;
  localparam int N32 = VEC_W / 32;

  logic [N8-1:0]  hit8;
  logic [N16-1:0] hit16;
  logic [N32-1:0] hit32, hitFp;
  logic           isSigned;
  logic [VEC_W-1:0] nextMask;

  assign isSigned = (ctrl.fmt == FMT_SINT);

  for (genvar g = 0; g < N8; g++) begin : g_l8
    simd_int_lane #(.W(8)) u_lane (
      .a(opA[g*8 +: 8]), .b(opB[g*8 +: 8]),
      .isSigned(isSigned), .rel(ctrl.rel), .hit(hit8[g]));
  end
  for (genvar g = 0; g < N16; g++) begin : g_l16
    simd_int_lane #(.W(16)) u_lane (
      .a(opA[g*16 +: 16]), .b(opB[g*16 +: 16]),
      .isSigned(isSigned), .rel(ctrl.rel), .hit(hit16[g]));
  end
  for (genvar g = 0; g < N32; g++) begin : g_l32
    simd_int_lane #(.W(32)) u_lane (
      .a(opA[g*32 +: 32]), .b(opB[g*32 +: 32]),
      .isSigned(isSigned), .rel(ctrl.rel), .hit(hit32[g]));
    simd_fp_lane u_fp (
      .a(opA[g*32 +: 32]), .b(opB[g*32 +: 32]),
      .rel(ctrl.rel), .hit(hitFp[g]));
  end

  always_comb begin
    for (int i = 0; i < VEC_W; i++) begin
      case (ctrl.lw)
        LW_8:    nextMask[i] = hit8[i/8];
        LW_16:   nextMask[i] = hit16[i/16];
        default: nextMask[i] = (ctrl.fmt == FMT_FP) ? hitFp[i/32] : hit32[i/32];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          resMask <= '0;
    else if (ctrl.load) resMask <= nextMask;
  end

  // R12: every byte of the mask is uniform
  for (genvar g = 0; g < N8; g++) begin : g_chk
    a_r12_byte_uniform: assert property (@(posedge clk) disable iff (!rstN)
      (resMask[g*8 +: 8] == 8'h00) || (resMask[g*8 +: 8] == 8'hFF));
  end
endmodule

// File: rtl/simd_cmp_unit.sv
module simd_cmp_unit
  import simd_cmp_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [31:0]      instr,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] resMask,
  output logic             resValid,
  output logic             illegal
);
  cmpCtrl_t ctrl;

  simd_cmp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .instr(instr),
    .ctrl(ctrl), .resValid(resValid), .illegal(illegal));

  simd_cmp_dp #(.VEC_W(VEC_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .opA(opA), .opB(opB), .resMask(resMask));

  // R11: a rejected request leaves the mask alone
  a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> $stable(resMask));
endmodule

// File: tb/test_simd_cmp_unit.sv
`timescale 1ns/1ps
module test_simd_cmp_unit;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] opA = '0, opB = '0;
  logic [127:0] resMask;
  logic         resValid, illegal;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  simd_cmp_unit i_simd_cmp_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .instr(instr),
    .opA(opA), .opB(opB), .resMask(resMask),
    .resValid(resValid), .illegal(illegal));

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(int op, bit b4, int sz, int u);
    return (32'(u) << 23) | (32'(sz) << 20) | (32'(op) << 8) | (32'(b4) << 4);
  endfunction

  // Float to ordered key: -0 folded to +0, negatives inverted
  function automatic logic [31:0] fkey(logic [31:0] x);
    if (x[30:0] == '0) x = '0;
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  function automatic bit isNan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // Independent reference: rel 0=eq 1=ge 2=gt; kind 0=signed 1=unsigned 2=float
  function automatic void model(logic [31:0] ins, logic [127:0] a, logic [127:0] b,
                                output bit legal, output logic [127:0] m);
    int op = int'(ins[11:8]), sz = int'(ins[21:20]), u = int'(ins[24:23]);
    bit b4 = ins[4];
    int rel = 0, kind = 0, w = 8;
    legal = 0; m = '0;
    if (op == 8 && b4 && u == 2 && sz < 3) begin legal = 1; rel = 0; kind = 1; end
    if (op == 3 && (u == 0 || u == 2) && sz < 3) begin
      legal = 1; rel = b4 ? 1 : 2; kind = (u == 2) ? 1 : 0;
    end
    if (op == 14 && !b4) begin
      kind = 2;
      if (sz == 0 && u == 0) begin legal = 1; rel = 0; end
      if (sz == 0 && u == 2) begin legal = 1; rel = 1; end
      if (sz == 2 && u == 2) begin legal = 1; rel = 2; end
    end
    if (!legal) return;
    w = (kind == 2) ? 32 : (8 << sz);
    for (int k = 0; k < 128 / w; k++) begin
      logic [31:0] wm = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      logic [31:0] la = 32'(a >> (k * w)) & wm;
      logic [31:0] lb = 32'(b >> (k * w)) & wm;
      logic [31:0] sb = 32'd1 << (w - 1);
      bit r;
      if (kind == 2) begin
        if (isNan(la) || isNan(lb)) r = 0;
        else begin
          la = fkey(la); lb = fkey(lb);
          r = (rel == 0) ? (la == lb) : (rel == 1) ? (la >= lb) : (la > lb);
        end
      end else begin
        if (kind == 0) begin la ^= sb; lb ^= sb; end
        r = (rel == 0) ? (la == lb) : (rel == 1) ? (la >= lb) : (la > lb);
      end
      if (r) m |= ({96'd0, wm} << (k * w));
    end
  endfunction

  task automatic runOp(string req, logic [31:0] ins, logic [127:0] a, logic [127:0] b);
    bit legal;
    logic [127:0] expM, prevM;
    model(ins, a, b, legal, expM);
    @(negedge clk);
    prevM = resMask;
    instr = ins; opA = a; opB = b; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk({req, " valid"}, 128'(resValid), 128'(legal));
    chk({req, " illegal"}, 128'(illegal), 128'(!legal));
    chk({req, " mask"}, resMask, legal ? expM : prevM);
  endtask

  task automatic t_reset();
    chk("R1 valid", 128'(resValid), 128'd0);
    chk("R1 illegal", 128'(illegal), 128'd0);
    chk("R1 mask", resMask, '0);
  endtask

  task automatic t_int_eq();
    logic [127:0] a = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
    logic [127:0] b = a ^ 128'h0000_0001_0000_0100_0000_0000_0100_0000;
    for (int sz = 0; sz < 3; sz++) runOp("R3 eq", enc(8, 1, sz, 2), a, b);
    runOp("R3 eq self", enc(8, 1, 2, 2), a, a);
    chk("R3 literal", resMask, {128{1'b1}});
  endtask

  task automatic t_ge();
    logic [127:0] a = {16{8'h80}}, b = {16{8'h7F}};
    runOp("R4 sge8", enc(3, 1, 0, 0), a, b);
    chk("R4 literal 80 vs 7F", resMask, '0);
    runOp("R5 uge8", enc(3, 1, 0, 2), a, b);
    chk("R5 literal 80 vs 7F", resMask, {128{1'b1}});
    for (int sz = 0; sz < 3; sz++) begin
      runOp("R4 sge", enc(3, 1, sz, 0), 128'hFFFF_0000_7FFF_8000_0001_FF00_1234_8001,
                                        128'h0000_FFFF_8000_7FFF_0001_00FF_1234_0001);
      runOp("R5 uge", enc(3, 1, sz, 2), 128'hFFFF_0000_7FFF_8000_0001_FF00_1234_8001,
                                        128'h0000_FFFF_8000_7FFF_0001_00FF_1234_0001);
    end
  endtask

  task automatic t_gt();
    logic [127:0] a = 128'h8000_0000_FFFF_FFFF_0000_0005_7FFF_FFFF;
    logic [127:0] b = 128'h7FFF_FFFF_0000_0000_0000_0005_8000_0000;
    for (int sz = 0; sz < 3; sz++) begin
      runOp("R6 sgt", enc(3, 0, sz, 0), a, b);
      runOp("R6 ugt", enc(3, 0, sz, 2), a, b);
    end
    runOp("R6 sgt32", enc(3, 0, 2, 0), a, b);
    chk("R6 literal", resMask, 128'h0000_0000_0000_0000_0000_0000_FFFF_FFFF);
  endtask

  task automatic t_size3();
    runOp("R7 eq sz3", enc(8, 1, 3, 2), '1, '1);
    runOp("R7 ge sz3", enc(3, 1, 3, 0), '1, '0);
    runOp("R7 gt sz3", enc(3, 0, 3, 2), '1, '0);
  endtask

  task automatic t_float();
    // lanes: +0/-0, -1/-2, inf/2.0, 1.0/1.0
    logic [127:0] a = {32'h0000_0000, 32'hBF80_0000, 32'h7F80_0000, 32'h3F80_0000};
    logic [127:0] b = {32'h8000_0000, 32'hC000_0000, 32'h4000_0000, 32'h3F80_0000};
    runOp("R8 feq", enc(14, 0, 0, 0), a, b);
    chk("R8 literal zeros", resMask, {32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF});
    runOp("R9 fge", enc(14, 0, 0, 2), a, b);
    runOp("R9 fgt", enc(14, 0, 2, 2), a, b);
    chk("R9 literal", resMask, {32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0});
    runOp("R9 fgt rev", enc(14, 0, 2, 2), b, a);
  endtask

  task automatic t_nan();
    logic [127:0] a = {32'h7FC0_0000, 32'h3F80_0000, 32'hFFC0_0001, 32'h7F80_0001};
    logic [127:0] b = {32'h7FC0_0000, 32'h7FC0_0000, 32'h3F80_0000, 32'h7F80_0001};
    runOp("R10 feq", enc(14, 0, 0, 0), a, b);
    chk("R10 literal", resMask, '0);
    runOp("R10 fge", enc(14, 0, 0, 2), a, b);
    runOp("R10 fgt", enc(14, 0, 2, 2), a, b);
  endtask

  task automatic t_illegal();
    runOp("R11 seed", enc(8, 1, 0, 2), 128'h1, 128'h1);
    runOp("R11 op5", enc(5, 1, 0, 2), '0, '0);
    runOp("R11 eq u0", enc(8, 1, 0, 0), '0, '0);
    runOp("R11 cmp u1", enc(3, 1, 0, 1), '0, '0);
    runOp("R11 fp b4", enc(14, 1, 0, 0), '0, '0);
    runOp("R11 fp sz1", enc(14, 0, 1, 2), '0, '0);
    runOp("R11 fp eq u2sz2", enc(14, 0, 2, 0), '0, '0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R2 idle valid", 128'(resValid), 128'd0);
    chk("R2 idle illegal", 128'(illegal), 128'd0);
  endtask

  task automatic t_lanes();
    // R12: mixed patterns at each width, compare to model
    for (int s = 0; s < 6; s++) begin
      logic [127:0] a = {4{32'h9E37_79B9 * (s + 1)}};
      logic [127:0] b = {a[63:0], ~a[63:32], a[31:0]};
      runOp("R12 lanes", enc(3, s[0], s % 3, (s / 3) * 2), a, b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_int_eq();
    t_ge();
    t_gt();
    t_size3();
    t_float();
    t_nan();
    t_illegal();
    t_idle();
    t_lanes();
    t_idle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule